// File: doc/BRIEF.md
# RTC Status and Array Write Guard

This block sits between the byte-write port of a small real-time-clock plus EEPROM device and its storage array. It holds the volatile status byte and a power-fail flag, and it decides for each array write whether the array sees it. The power-fail flag is set when both supplies are gone at the same time. Losing only one supply leaves the flag alone. The flag clears on the next byte written to the clock's register space.

A 3-bit protect code, held elsewhere in nonvolatile storage, is decoded against the 9-bit array address. The result gates the array write-enable in the same cycle. A write that falls in the protected range is dropped with no indication. The status byte on the read side always returns zero in its two reserved positions.

Top module: `rtc_status_guard`

## Requirements
- R1: While reset is asserted and right after it, `status` reads 8'h01: the power-fail flag (bit 0) is 1 and every other bit is 0.
- R2: In any cycle where `main_ok` and `bkup_ok` are both low, the power-fail flag is 1 from the next cycle on. It stays 1 after power returns, whichever supply comes back first.
- R3: While at least one supply is good and no clock-register write happens, the power-fail flag keeps its value. A single supply dropping therefore never sets it.
- R4: A one-cycle `rtc_wr` while at least one supply is good clears the power-fail flag in the next cycle, whatever `wdata` holds. Writing 1 to bit 0 of the status byte cannot set the flag.
- R5: Bits 4 and 3 of `status` always read 0, including after a status write of 8'hFF.
- R6: `rtc_wr` with `sr_sel` high stores `wdata` bits 7, 6, 5, 2 and 1 into the same `status` bits in the next cycle. `rtc_wr` with `sr_sel` low leaves them unchanged. A cycle with both supplies low clears them to 0.
- R7: `prot_code` selects the protected address range: 0 none, 1 180h..1FFh, 2 100h..1FFh, 3 all, 4 000h..03Fh, 5 000h..07Fh, 6 000h..0FFh, 7 all. The range limits scale with the array size as 3/4, 1/2, 1/8 and 1/4 of the span.
- R8: `arr_we` is high in the same cycle as `arr_wr` when `arr_addr` is outside the protected range, and low otherwise. It is never high without `arr_wr`.
- R9: With `prot_code` 3 or 7, `arr_we` stays low at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ok | input | 1 | Main supply is good |
| bkup_ok | input | 1 | Backup supply is good |
| rtc_wr | input | 1 | One-cycle byte write into the clock register space |
| sr_sel | input | 1 | The clock-register write targets the status byte |
| wdata | input | 8 | Write data byte |
| arr_wr | input | 1 | Write strobe toward the storage array |
| arr_addr | input | AW (9) | Array byte address |
| prot_code | input | 3 | Protect range code from nonvolatile settings |
| arr_we | output | 1 | Gated write-enable to the array |
| status | output | 8 | Status byte as read by the host |

## Verification
The properties assume that the supply-good inputs and write strobes are synchronous to `clk` and stable across each edge. They also assume that `prot_code` changes only between writes. The bench changes every input one time unit after a rising edge and holds it for at least one full cycle. It reads registered results one edge later and reads the combinational write-enable within the same cycle. Power sequences are stepped one supply at a time, so each property sees the single-loss and total-loss cases in turn.

// File: rtl/rtc_status_guard.sv
module rtc_status_guard #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          main_ok,
  input  logic          bkup_ok,
  input  logic          rtc_wr,
  input  logic          sr_sel,
  input  logic [7:0]    wdata,
  input  logic          arr_wr,
  input  logic [AW-1:0] arr_addr,
  input  logic [2:0]    prot_code,
  output logic          arr_we,
  output logic [7:0]    status
);
  localparam int SPAN = 1 << AW;
  localparam logic [AW-1:0] LIM_Q3  = AW'(SPAN * 3 / 4);
  localparam logic [AW-1:0] LIM_HLF = AW'(SPAN / 2);
  localparam logic [AW-1:0] LIM_QTR = AW'(SPAN / 4);
  localparam logic [AW-1:0] LIM_8TH = AW'(SPAN / 8);
  localparam logic [7:0]    KEEP    = 8'hE6;

  logic       fail;
  logic [7:0] kept;
  logic       hit;
  logic       powered;

  assign powered = main_ok | bkup_ok;

  always_comb begin
    unique case (prot_code)
      3'd0:    hit = 1'b0;
      3'd1:    hit = arr_addr >= LIM_Q3;
      3'd2:    hit = arr_addr >= LIM_HLF;
      3'd4:    hit = arr_addr <  LIM_8TH;
      3'd5:    hit = arr_addr <  LIM_QTR;
      3'd6:    hit = arr_addr <  LIM_HLF;
      default: hit = 1'b1;
    endcase
  end

  assign arr_we = arr_wr & ~hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail <= 1'b1;
      kept <= 8'h00;
    end else if (!powered) begin
      fail <= 1'b1;
      kept <= 8'h00;
    end else if (rtc_wr) begin
      fail <= 1'b0;
      if (sr_sel) kept <= wdata & KEEP;
    end
  end

  assign status = {kept[7:1], fail};
endmodule

// File: rtl/rtc_status_guard_chk.sv
module rtc_status_guard_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          main_ok,
  input logic          bkup_ok,
  input logic          rtc_wr,
  input logic          arr_wr,
  input logic [AW-1:0] arr_addr,
  input logic [2:0]    prot_code,
  input logic          arr_we,
  input logic [7:0]    status
);
  p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[4:3] == 2'b00);

  p_loss_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_ok && !bkup_ok) |=> status[0]);

  p_single_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_ok || bkup_ok) && !rtc_wr) |=> $stable(status[0]));

  p_wr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_ok || bkup_ok) && rtc_wr) |=> !status[0]);

  p_loss_wipes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_ok && !bkup_ok) |=> status[7:1] == 7'd0);

  p_none_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_code == 3'd0) |-> (arr_we == arr_wr));

  p_we_needs_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> arr_wr);

  p_full_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_code == 3'd3 || prot_code == 3'd7) |-> !arr_we);

  p_top_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_code == 3'd4 && arr_wr && arr_addr == {AW{1'b1}}) |-> arr_we);
endmodule

bind rtc_status_guard rtc_status_guard_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .bkup_ok(bkup_ok),
  .rtc_wr(rtc_wr), .arr_wr(arr_wr), .arr_addr(arr_addr),
  .prot_code(prot_code), .arr_we(arr_we), .status(status)
);

// File: tb/test_rtc_status_guard.sv
module test_rtc_status_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_ok = 1'b1, bkup_ok = 1'b1;
  logic       rtc_wr = 1'b0, sr_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       arr_wr = 1'b0;
  logic [8:0] arr_addr = 9'h000;
  logic [2:0] prot_code = 3'd0;
  logic       arr_we;
  logic [7:0] status;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rtc_status_guard #(.AW(9)) i_rtc_status_guard (
    .clk(clk), .rst_n(rst_n), .main_ok(main_ok), .bkup_ok(bkup_ok),
    .rtc_wr(rtc_wr), .sr_sel(sr_sel), .wdata(wdata), .arr_wr(arr_wr),
    .arr_addr(arr_addr), .prot_code(prot_code), .arr_we(arr_we),
    .status(status)
  );

  // {expected arr_we, prot_code, arr_addr}
  localparam logic [12:0] VEC [24] = '{
    {1'b1,3'd0,9'h000}, {1'b1,3'd0,9'h1FF},
    {1'b1,3'd1,9'h17F}, {1'b0,3'd1,9'h180}, {1'b0,3'd1,9'h1FF}, {1'b1,3'd1,9'h000},
    {1'b1,3'd2,9'h0FF}, {1'b0,3'd2,9'h100}, {1'b1,3'd2,9'h000},
    {1'b0,3'd3,9'h000}, {1'b0,3'd3,9'h1FF},
    {1'b0,3'd4,9'h03F}, {1'b1,3'd4,9'h040}, {1'b1,3'd4,9'h1FF},
    {1'b0,3'd5,9'h07F}, {1'b1,3'd5,9'h080},
    {1'b0,3'd6,9'h0FF}, {1'b1,3'd6,9'h100}, {1'b0,3'd6,9'h000}, {1'b1,3'd6,9'h1FF},
    {1'b0,3'd7,9'h000}, {1'b0,3'd7,9'h100}, {1'b0,3'd7,9'h1FF}, {1'b0,3'd2,9'h1FF}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rtc_write(input logic sel, input logic [7:0] d);
    rtc_wr = 1'b1; sr_sel = sel; wdata = d;
    step();
    rtc_wr = 1'b0; sr_sel = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #7;
    chk("R1 in reset", status, 8'h01);
    step();
    rst_n = 1'b1;
    step();
    chk("R1 after reset", status, 8'h01);

    // R7 R8 R9: protect map walk
    arr_wr = 1'b1;
    foreach (VEC[i]) begin
      prot_code = VEC[i][11:9];
      arr_addr  = VEC[i][8:0];
      #1;
      chk($sformatf("R7 R8 R9 code %0d addr %0h", VEC[i][11:9], VEC[i][8:0]),
          arr_we, VEC[i][12]);
    end
    arr_wr = 1'b0;
    prot_code = 3'd0; arr_addr = 9'h055;
    #1;
    chk("R8 no strobe", arr_we, 0);
    step();

    // R4: any RTC byte write clears the flag, bit 0 data cannot set it
    rtc_write(1'b0, 8'h01);
    chk("R4 clear", status, 8'h00);
    rtc_write(1'b1, 8'h01);
    chk("R4 read-only bit0", status, 8'h00);

    // R3: single supply losses
    main_ok = 1'b0;
    step(); step(); step();
    chk("R3 main lost", status[0], 0);
    main_ok = 1'b1; step();
    bkup_ok = 1'b0;
    step(); step();
    chk("R3 backup lost", status[0], 0);
    bkup_ok = 1'b1; step();

    // R5 R6: status latch bits
    rtc_write(1'b1, 8'hFF);
    chk("R5 R6 write FF", status, 8'hE6);
    rtc_write(1'b0, 8'h00);
    chk("R6 other register", status, 8'hE6);

    // R2: total loss, main returns first
    main_ok = 1'b0; step();
    bkup_ok = 1'b0; step();
    chk("R2 R6 both down", status, 8'h01);
    main_ok = 1'b1; step(); step();
    chk("R2 main first", status, 8'h01);
    bkup_ok = 1'b1; step();
    rtc_write(1'b1, 8'h12);
    chk("R4 R5 R6 clear and store", status, 8'h02);

    // R2: total loss, backup returns first
    bkup_ok = 1'b0; step();
    main_ok = 1'b0; step();
    bkup_ok = 1'b1; step(); step();
    chk("R2 backup first", status, 8'h01);
    main_ok = 1'b1; step();
    chk("R2 held", status[0], 1);

    // R4: clear then single loss keeps it clear
    rtc_write(1'b0, 8'hAA);
    chk("R4 plain write", status[0], 0);
    bkup_ok = 1'b0; step(); bkup_ok = 1'b1; step();
    chk("R3 stays clear", status[0], 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule